// File: doc/BRIEF.md
# Streaming Window Classifier with Partial-Sum Accumulation

This block scores every detection window of an image against a trained linear classifier. It does not wait for a window's full feature vector to exist. Normalised block descriptors arrive one block at a time in raster order over a grid of blocks. Each descriptor has 36 signed values: 9 orientation bins from each of the 4 cells of the block. The block folds each descriptor into the running dot product of every window that contains it. The descriptor is consumed as it arrives and is not kept once its contribution is made. Between arrivals, each window position keeps only one signed partial sum of `ACC_W` bits.

A window spans `WIN_BW` × `WIN_BH` blocks. The defaults, 7 × 15, match an 8 × 16 cell region with one-cell block stride. Processing is split across `WIN_BW` lanes. Each lane has one multiplier and one adder, and lane `dx` serves the window whose left edge is `dx` block columns to the left of the arriving block. The window rows containing the block are visited in turn. Weights come from an external synchronous memory. That memory returns one word holding the weights of every lane for a given row offset and feature index.

The last block of a window is its bottom-right block. When that block has been added, the window's sum plus a signed bias is tested against zero. A one-cycle result then gives the detection bit and the window's origin in block coordinates.

Top module: `cwc_classifier`

## Requirements
- R1: `blk_ready` is high when the block is idle. A block is taken on a rising edge where `blk_valid` and `blk_ready` are both high. `blk_ready` is then low for exactly 36·`WIN_BH` cycles, one per issued multiply step, and high again afterwards.
- R2: After acceptance, one weight address is issued per cycle, starting in the first cycle. `w_addr` = {dy, k}, where k (feature index 0..35) fills the low ceil(log2 36) = 6 bits and dy is the window row offset in the bits above. k counts fastest, and dy runs 0..`WIN_BH`-1. `w_data` answers an address presented in one cycle during the next cycle.
- R3: Feature k of a block is the two's-complement field `blk_feat[k*FEAT_W +: FEAT_W]`. The weight applied by lane dx (window column offset dx) is the two's-complement field `w_data[dx*WGT_W +: WGT_W]`.
- R4: A window's score is the sum over its block offsets (dx, dy) and k of weight(dx, dy, k) × feature(k) of block (origin_x+dx, origin_y+dy). `win_det` is 1 exactly when score + `bias` > 0, so a total of zero gives 0.
- R5: A window's result appears only once. `win_valid` is high for one cycle, starting at the (36·`WIN_BH`+1)-th rising edge after the edge that accepted the window's bottom-right block.
- R6: Results are reported only for windows lying wholly inside the `GRID_BW` × `GRID_BH` block grid. `win_x`/`win_y` hold the window's top-left block. A block with x < `WIN_BW`-1 or y < `WIN_BH`-1 produces no result.
- R7: A window's sum starts from zero when its top-left block is accepted. Sums left from an earlier frame have no effect on a new frame's results.
- R8: `blk_valid`, `blk_x`, `blk_y` and `blk_feat` have no effect while `blk_ready` is low.
- R9: After reset, `blk_ready` is 1 and `win_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | Block descriptor offered |
| blk_ready | output | 1 | Block idle and able to take a descriptor |
| blk_x | input | XW (4) | Block column in the grid |
| blk_y | input | YW (5) | Block row in the grid |
| blk_feat | input | N_FEAT·FEAT_W (324) | 36 signed features, feature k at bits k·FEAT_W |
| w_addr | output | DW+KW (10) | Weight address {row offset, feature index} |
| w_data | input | WIN_BW·WGT_W (28) | Weights for all lanes, one cycle after the address |
| bias | input | ACC_W (29) | Signed bias added before the zero test |
| win_valid | output | 1 | Window result pulse |
| win_x | output | XW (4) | Window origin column (block units) |
| win_y | output | YW (5) | Window origin row (block units) |
| win_det | output | 1 | 1 when score + bias > 0 |

## Verification
The bench uses a reduced configuration: 2 × 2 block windows on a 4 × 3 grid. Every block of several whole frames is swept, and each window score is recomputed arithmetically. Full-scale negative features against −8 and +7 weights catch truncated products or sign loss, and a mis-sliced lane or feature field would score the wrong window. Frames are chosen so that score + bias equals exactly 0 and exactly 1, to catch a ≥/> mix-up. Back-to-back frames with different data catch a design that fails to clear a window's sum at its first block, which would carry one frame into the next. Descriptors offered during a busy period catch a handshake that latches data while busy. Each block is also checked for its pulse's cycle and count and for its address sequence, so a missing, doubled or early result, or an off-by-one address or latency, shows at the ports.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cwc_seq.sv
// Takes one block descriptor, then steps (row offset, feature) one per cycle.
// Issue stage registers line up with the one-cycle weight read latency.
module cwc_seq
  import cwc_pkg::*;
#(
  parameter int FEAT_W = 9,
  parameter int N_FEAT = 36,
  parameter int WIN_BH = 15,
  parameter int XW     = 4,
  parameter int YW     = 5,
  localparam int KW    = idx_w(N_FEAT),
  localparam int DW    = idx_w(WIN_BH),
  localparam int VW    = N_FEAT * FEAT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     blk_valid,
  output logic                     blk_ready,
  input  logic [XW-1:0]            blk_x,
  input  logic [YW-1:0]            blk_y,
  input  logic [VW-1:0]            blk_feat,
  output logic [DW+KW-1:0]         w_addr,
  output logic [XW-1:0]            cur_x,
  output logic [YW-1:0]            cur_y,
  output logic                     iss_v,
  output logic                     iss_first,
  output logic                     iss_last,
  output logic [DW-1:0]            iss_dy,
  output logic signed [FEAT_W-1:0] iss_feat
);

  seq_state_e      state_q;
  logic [DW-1:0]   dy_q;
  logic [KW-1:0]   k_q;
  logic [VW-1:0]   feat_q;
  logic            k_end;
  logic            dy_end;

  assign k_end     = (k_q == KW'(N_FEAT - 1));
  assign dy_end    = (dy_q == DW'(WIN_BH - 1));
  assign blk_ready = (state_q == SEQ_IDLE);
  assign w_addr    = {dy_q, k_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      dy_q      <= '0;
      k_q       <= '0;
      cur_x     <= '0;
      cur_y     <= '0;
      iss_v     <= 1'b0;
      iss_first <= 1'b0;
      iss_last  <= 1'b0;
      iss_dy    <= '0;
      iss_feat  <= '0;
    end else begin
      iss_v     <= (state_q == SEQ_RUN);
      iss_first <= (k_q == '0);
      iss_last  <= k_end;
      iss_dy    <= dy_q;
      iss_feat  <= feat_q[k_q*FEAT_W +: FEAT_W];
      unique case (state_q)
        SEQ_IDLE: begin
          if (blk_valid) begin
            cur_x   <= blk_x;
            cur_y   <= blk_y;
            dy_q    <= '0;
            k_q     <= '0;
            state_q <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (k_end) begin
            k_q <= '0;
            if (dy_end) state_q <= SEQ_IDLE;
            else        dy_q    <= dy_q + 1'b1;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // the arriving descriptor is held only while it is being consumed
  always_ff @(posedge clk) begin
    if (state_q == SEQ_IDLE && blk_valid) feat_q <= blk_feat;
  end

endmodule

// File: rtl/cwc_pe.sv
// One lane: a multiplier and an adder folding products into a window sum.
module cwc_pe #(
  parameter int FEAT_W = 9,
  parameter int WGT_W  = 4,
  parameter int ACC_W  = 29,
  localparam int PW    = FEAT_W + WGT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     first,
  input  logic                     zero_base,
  input  logic signed [ACC_W-1:0]  stored,
  input  logic signed [WGT_W-1:0]  wgt,
  input  logic signed [FEAT_W-1:0] feat,
  output logic signed [ACC_W-1:0]  sum
);

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] acc_q;

  assign prod = wgt * feat;

  always_comb begin
    if (first) base = zero_base ? '0 : stored;
    else       base = acc_q;
  end

  assign sum = base + {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= sum;
  end

endmodule

// File: rtl/cwc_psum_store.sv
// Per-window partial sums, one entry per window origin, one port per lane.
module cwc_psum_store #(
  parameter int ACC_W  = 29,
  parameter int NUM_PE = 7,
  parameter int NWX    = 10,
  parameter int NWY    = 10,
  parameter int XW     = 4,
  parameter int YW     = 5
) (
  input  logic                           clk,
  input  logic [YW-1:0]                  row,
  input  logic [NUM_PE-1:0][XW-1:0]      col,
  input  logic [NUM_PE-1:0]              we,
  input  logic [NUM_PE-1:0][ACC_W-1:0]   wdata,
  output logic [NUM_PE-1:0][ACC_W-1:0]   rdata
);

  logic [ACC_W-1:0] mem_q [NWY][NWX];

  for (genvar l = 0; l < NUM_PE; l++) begin : g_rd
    always_comb begin
      rdata[l] = '0;
      if (int'(row) < NWY && int'(col[l]) < NWX) rdata[l] = mem_q[row][col[l]];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_PE; l++) begin
      if (we[l] && int'(row) < NWY && int'(col[l]) < NWX) mem_q[row][col[l]] <= wdata[l];
    end
  end

endmodule

// File: rtl/cwc_classifier.sv
// Streaming linear window classifier: lanes, partial-sum store, decision.
module cwc_classifier
  import cwc_pkg::*;
#(
  parameter int FEAT_W  = 9,
  parameter int WGT_W   = 4,
  parameter int ACC_W   = 29,
  parameter int N_FEAT  = 36,
  parameter int WIN_BW  = 7,
  parameter int WIN_BH  = 15,
  parameter int GRID_BW = 16,
  parameter int GRID_BH = 24,
  localparam int NUM_PE = WIN_BW,
  localparam int NWX    = GRID_BW - WIN_BW + 1,
  localparam int NWY    = GRID_BH - WIN_BH + 1,
  localparam int XW     = idx_w(GRID_BW),
  localparam int YW     = idx_w(GRID_BH),
  localparam int KW     = idx_w(N_FEAT),
  localparam int DW     = idx_w(WIN_BH),
  localparam int AW     = DW + KW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        blk_valid,
  output logic                        blk_ready,
  input  logic [XW-1:0]               blk_x,
  input  logic [YW-1:0]               blk_y,
  input  logic [N_FEAT*FEAT_W-1:0]    blk_feat,
  output logic [AW-1:0]               w_addr,
  input  logic [NUM_PE*WGT_W-1:0]     w_data,
  input  logic [ACC_W-1:0]            bias,
  output logic                        win_valid,
  output logic [XW-1:0]               win_x,
  output logic [YW-1:0]               win_y,
  output logic                        win_det
);

  logic [XW-1:0]               cur_x;
  logic [YW-1:0]               cur_y;
  logic                        iss_v, iss_first, iss_last;
  logic [DW-1:0]               iss_dy;
  logic signed [FEAT_W-1:0]    iss_feat;
  logic [YW:0]                 wy_ext;
  logic                        row_ok;
  logic [NUM_PE-1:0]           lane_ok;
  logic [NUM_PE-1:0]           lane_we;
  logic [NUM_PE-1:0][XW-1:0]   lane_col;
  logic [NUM_PE-1:0][ACC_W-1:0] lane_sum;
  logic [NUM_PE-1:0][ACC_W-1:0] lane_stored;
  logic                        done;
  logic signed [ACC_W:0]       total;

  cwc_seq #(
    .FEAT_W(FEAT_W), .N_FEAT(N_FEAT), .WIN_BH(WIN_BH), .XW(XW), .YW(YW)
  ) u_seq (
    .clk(clk), .rst(rst),
    .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_x(blk_x), .blk_y(blk_y), .blk_feat(blk_feat),
    .w_addr(w_addr), .cur_x(cur_x), .cur_y(cur_y),
    .iss_v(iss_v), .iss_first(iss_first), .iss_last(iss_last),
    .iss_dy(iss_dy), .iss_feat(iss_feat)
  );

  // window row served in this pass
  assign wy_ext = {1'b0, cur_y} - (YW+1)'(iss_dy);
  assign row_ok = !wy_ext[YW] && (int'(wy_ext[YW-1:0]) < NWY);

  for (genvar dx = 0; dx < NUM_PE; dx++) begin : g_lane
    logic [XW:0] wx_ext;
    assign wx_ext       = {1'b0, cur_x} - (XW+1)'(dx);
    assign lane_col[dx] = wx_ext[XW-1:0];
    assign lane_ok[dx]  = row_ok && !wx_ext[XW] && (int'(wx_ext[XW-1:0]) < NWX);
    assign lane_we[dx]  = iss_v && iss_last && lane_ok[dx];

    cwc_pe #(
      .FEAT_W(FEAT_W), .WGT_W(WGT_W), .ACC_W(ACC_W)
    ) u_pe (
      .clk(clk), .rst(rst),
      .en(iss_v),
      .first(iss_first),
      .zero_base((dx == 0) && (iss_dy == '0)),
      .stored(lane_stored[dx]),
      .wgt(w_data[dx*WGT_W +: WGT_W]),
      .feat(iss_feat),
      .sum(lane_sum[dx])
    );
  end

  cwc_psum_store #(
    .ACC_W(ACC_W), .NUM_PE(NUM_PE), .NWX(NWX), .NWY(NWY), .XW(XW), .YW(YW)
  ) u_store (
    .clk(clk),
    .row(wy_ext[YW-1:0]),
    .col(lane_col),
    .we(lane_we),
    .wdata(lane_sum),
    .rdata(lane_stored)
  );

  // the leftmost window in the topmost row closes with this block
  assign done  = iss_v && iss_last && (iss_dy == DW'(WIN_BH - 1)) && lane_ok[NUM_PE-1];
  assign total = {lane_sum[NUM_PE-1][ACC_W-1], lane_sum[NUM_PE-1]}
               + {bias[ACC_W-1], bias};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_x     <= '0;
      win_y     <= '0;
      win_det   <= 1'b0;
    end else begin
      win_valid <= done;
      if (done) begin
        win_x   <= cur_x - XW'(WIN_BW - 1);
        win_y   <= cur_y - YW'(WIN_BH - 1);
        win_det <= !total[ACC_W] && (total != '0);
      end
    end
  end

endmodule

// File: rtl/cwc_classifier_chk.sv
module cwc_classifier_chk #(
  parameter int N_FEAT = 36,
  parameter int NWX    = 10,
  parameter int NWY    = 10,
  parameter int KW     = 6,
  parameter int AW     = 10,
  parameter int XW     = 4,
  parameter int YW     = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          blk_valid,
  input logic          blk_ready,
  input logic [AW-1:0] w_addr,
  input logic          win_valid,
  input logic [XW-1:0] win_x,
  input logic [YW-1:0] win_y
);

  // R1: an accepted block makes the block busy on the next cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_ready) |=> !blk_ready);

  // R2: the first address after acceptance is row 0, feature 0
  p_first_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_ready) |=> (w_addr == '0));

  // R2: feature index stays inside the descriptor while busy
  p_k_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !blk_ready |-> (int'(w_addr[KW-1:0]) < N_FEAT));

  // R2: feature index steps by one inside a row pass
  p_k_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!blk_ready && int'(w_addr[KW-1:0]) != N_FEAT - 1)
      |=> (w_addr[KW-1:0] == KW'($past(w_addr[KW-1:0]) + 1'b1)));

  // R5: a result is a single-cycle pulse
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> !win_valid);

  // R6: reported origins lie inside the grid of whole windows
  p_origin_range_r6: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (int'(win_x) < NWX && int'(win_y) < NWY));

endmodule

bind cwc_classifier cwc_classifier_chk #(
  .N_FEAT(N_FEAT), .NWX(NWX), .NWY(NWY), .KW(KW), .AW(AW), .XW(XW), .YW(YW)
) u_chk (
  .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .w_addr(w_addr), .win_valid(win_valid), .win_x(win_x), .win_y(win_y)
);

// File: tb/cwc_classifier_test.sv
module cwc_classifier_test;

  localparam int FEAT_W = 9;
  localparam int WGT_W  = 4;
  localparam int ACC_W  = 29;
  localparam int NF     = 36;
  localparam int W      = 2;
  localparam int H      = 2;
  localparam int GW     = 4;
  localparam int GH     = 3;
  localparam int XW     = 2;
  localparam int YW     = 2;
  localparam int KW     = 6;
  localparam int AW     = 7;
  localparam int STEPS  = NF * H;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   blk_valid = 1'b0;
  logic                   blk_ready;
  logic [XW-1:0]          blk_x = '0;
  logic [YW-1:0]          blk_y = '0;
  logic [NF*FEAT_W-1:0]   blk_feat = '0;
  logic [AW-1:0]          w_addr;
  logic [W*WGT_W-1:0]     w_data = '0;
  logic [ACC_W-1:0]       bias = '0;
  logic                   win_valid;
  logic [XW-1:0]          win_x;
  logic [YW-1:0]          win_y;
  logic                   win_det;

  logic [W*WGT_W-1:0] wmem [0:(1<<AW)-1];
  int fe [0:GH-1][0:GW-1][0:NF-1];
  int checks = 0;
  int errors = 0;
  int bias_i = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) w_data <= wmem[w_addr];

  cwc_classifier #(
    .FEAT_W(FEAT_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .N_FEAT(NF),
    .WIN_BW(W), .WIN_BH(H), .GRID_BW(GW), .GRID_BH(GH)
  ) uut (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_x(blk_x), .blk_y(blk_y), .blk_feat(blk_feat),
    .w_addr(w_addr), .w_data(w_data), .bias(bias),
    .win_valid(win_valid), .win_x(win_x), .win_y(win_y), .win_det(win_det)
  );

  function automatic int mix(input int a);
    int v;
    v = a * 1103515245 + 12345;
    v = v ^ (v >>> 13);
    return v;
  endfunction

  function automatic int wval(input int dx, input int dy, input int k);
    if (k == 0) return -8;
    if (k == 1) return 7;
    return ((mix(dx*31 + dy*17 + k*5 + 1000) >> 6) & 15) - 8;
  endfunction

  function automatic int score(input int wx, input int wy);
    int s = 0;
    for (int dy = 0; dy < H; dy++)
      for (int dx = 0; dx < W; dx++)
        for (int k = 0; k < NF; k++)
          s += wval(dx, dy, k) * fe[wy+dy][wx+dx][k];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode 0: hashed, 1: all minimum, 2: all zero
  task automatic fill_frame(input int mode, input int seed);
    for (int y = 0; y < GH; y++)
      for (int x = 0; x < GW; x++)
        for (int k = 0; k < NF; k++)
          case (mode)
            0: fe[y][x][k] = ((mix(seed*7919 + y*613 + x*97 + k) >> 4) & 511) - 256;
            1: fe[y][x][k] = -256;
            default: fe[y][x][k] = 0;
          endcase
  endtask

  task automatic run_block(input int bx, input int by, input bit garbage);
    int npulse = 0;
    int at = -1;
    int px = 0;
    int py = 0;
    int pd = 0;
    bit addr_ok = 1'b1;
    bit rdy_ok = 1'b1;
    int bad_addr = 0;
    int exp_addr = 0;
    bit completes;
    int exp_det;
    logic [NF*FEAT_W-1:0] v;
    for (int k = 0; k < NF; k++) v[k*FEAT_W +: FEAT_W] = FEAT_W'(fe[by][bx][k]);
    while (!blk_ready) @(negedge clk);
    blk_valid = 1'b1;
    blk_x = XW'(bx);
    blk_y = YW'(by);
    blk_feat = v;
    @(negedge clk);
    blk_valid = 1'b0;
    if (w_addr != '0) begin addr_ok = 1'b0; bad_addr = int'(w_addr); end
    if (blk_ready) rdy_ok = 1'b0;
    for (int i = 2; i <= STEPS + 2; i++) begin
      @(negedge clk);
      if (garbage && i == 5) begin
        blk_valid = 1'b1;
        blk_x = XW'(GW - 1 - bx);
        blk_y = '0;
        blk_feat = ~v;
      end
      if (garbage && i == 9) blk_valid = 1'b0;
      if (i <= STEPS) begin
        exp_addr = ((i - 1) / NF) * (1 << KW) + ((i - 1) % NF);
        if (int'(w_addr) != exp_addr && addr_ok) begin addr_ok = 1'b0; bad_addr = int'(w_addr); end
        if (blk_ready) rdy_ok = 1'b0;
      end
      if (i == STEPS + 1 && !blk_ready) rdy_ok = 1'b0;
      if (win_valid) begin
        npulse++;
        at = i; px = int'(win_x); py = int'(win_y); pd = int'(win_det);
      end
    end
    chk(addr_ok, "R2", "weight address sequence", bad_addr, exp_addr);
    chk(rdy_ok, "R1", "ready low for exactly 36*WIN_BH cycles", int'(rdy_ok), 1);
    completes = (bx >= W - 1) && (by >= H - 1);
    if (!completes) begin
      chk(npulse == 0, "R6", "no result for block outside window corner", npulse, 0);
    end else begin
      exp_det = (score(bx - W + 1, by - H + 1) + bias_i > 0) ? 1 : 0;
      chk(npulse == 1 && at == STEPS + 2, "R5", "pulse count/cycle", npulse*1000 + at, 1000 + STEPS + 2);
      chk(px == bx - W + 1 && py == by - H + 1, "R6", "window origin", px*16 + py,
          (bx - W + 1)*16 + (by - H + 1));
      chk(pd == exp_det, "R4", "detection bit (R3 field order)", pd, exp_det);
    end
  endtask

  task automatic run_frame(input bit garbage);
    for (int y = 0; y < GH; y++)
      for (int x = 0; x < GW; x++)
        run_block(x, y, garbage);
  endtask

  task automatic set_bias(input int b);
    bias_i = b;
    bias = ACC_W'(b);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin
      wmem[a] = '0;
      for (int dx = 0; dx < W; dx++)
        if ((a % (1 << KW)) < NF && (a / (1 << KW)) < H)
          wmem[a][dx*WGT_W +: WGT_W] = WGT_W'(wval(dx, a / (1 << KW), a % (1 << KW)));
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(blk_ready == 1'b1, "R9", "ready after reset", int'(blk_ready), 1);
    chk(win_valid == 1'b0, "R9", "no result after reset", int'(win_valid), 0);

    fill_frame(0, 1); set_bias(0);       run_frame(1'b0);
    // R7: following frames must not inherit earlier sums
    fill_frame(1, 0); set_bias(0);       run_frame(1'b0);
    fill_frame(2, 0); set_bias(0);       run_frame(1'b0);
    fill_frame(2, 0); set_bias(1);       run_frame(1'b0);
    fill_frame(0, 2); set_bias(-score(0, 0));     run_frame(1'b0);
    fill_frame(0, 2); set_bias(1 - score(0, 0));  run_frame(1'b0);
    // R8: offers made while busy carry other data and must be ignored
    fill_frame(0, 3); set_bias(-5000);   run_frame(1'b1);
    fill_frame(0, 4); set_bias(3000);    run_frame(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule